// File: doc/BRIEF.md
# Variable-Length Instruction Byte Aligner

The aligner takes instruction bytes one per cycle from a valid/ready byte stream and rebuilds whole instructions from them. The first byte of every instruction is its opcode. The two top bits of that opcode give the instruction's total length, which is 2, 4 or 6 bytes. The aligner collects the remaining bytes. When the last one arrives, it presents a single unpacked record on a valid/ready output. The record holds the opcode, a format tag, the register nibbles, the immediate or length fields, and up to two base/displacement pairs.

Format selection is fixed by opcode bits, except for one case. For 6-byte storage-to-storage instructions, a parameterised list of opcodes picks the variant in which the second byte carries two 4-bit lengths instead of one 8-bit length. The record stays on the output until it is accepted, and while it waits, no new bytes are taken. A synchronous flush discards a half-collected instruction and any record that is waiting. The block does not execute instructions, fetch from memory or check whether an opcode is valid.

Top module: `insn_byte_aligner`

## Requirements
- R1: Let op[7:6] be the top two bits of the opcode. If op[7:6] is 00, the instruction is 2 bytes long. If it is 01 or 10, the instruction is 4 bytes long. If it is 11, the instruction is 6 bytes long. A record is emitted after exactly that many accepted bytes, and `len_o` reports the length.
- R2: `fmt_o` is set from the opcode as follows.
  - 0 (register-register) when op[7:6]=00.
  - 1 (register-indexed) when op[7:6]=01.
  - 2 (register-storage) when op[7:6]=10 and op[5]=0.
  - 3 (storage-immediate) when op[7:6]=10 and op[5]=1.
  - 5 (storage-storage, dual 4-bit lengths) when op[7:6]=11 and the opcode is in the list F2, F3, F8, FA.
  - 4 (storage-storage, single 8-bit length) for any other opcode with op[7:6]=11.
- R3: For tags 0, 1 and 2, `ra_o` is bits 7:4 of byte 2 and `rb_o` is bits 3:0 of byte 2.
- R4: For tag 3, `imm_o` equals byte 2.
- R5: For tag 4, `len8_o` equals byte 2. For tag 5, `lhi_o` is bits 7:4 of byte 2 and `llo_o` is bits 3:0 of byte 2.
- R6: For every tag except 0, `base1_o` is bits 7:4 of byte 3 and `disp1_o` is {byte 3 bits 3:0, byte 4}. For tags 4 and 5, `base2_o` and `disp2_o` are taken in the same way from bytes 5 and 6.
- R7: Every output field that the record's format does not use is zero.
- R8: While `out_valid` is high and `out_ready` is low, the record holds unchanged and `in_ready` is low.
- R9: When `out_ready` is high, `in_ready` stays high across instruction boundaries. `out_valid` rises in the cycle after the last byte of an instruction is accepted.
- R10: A cycle with `flush` high does the following.
  - It holds `in_ready` low.
  - It drops any pending record.
  - It discards partial bytes, so the next accepted byte is treated as an opcode.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard partial instruction and pending record |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Record accepted by consumer |
| op_o | output | 8 | Opcode |
| fmt_o | output | 3 | Format tag (R2) |
| len_o | output | 3 | Instruction length in bytes |
| ra_o | output | 4 | First register nibble |
| rb_o | output | 4 | Second register/index nibble |
| imm_o | output | 8 | Immediate byte |
| len8_o | output | 8 | Single 8-bit operand length |
| lhi_o | output | 4 | First 4-bit operand length |
| llo_o | output | 4 | Second 4-bit operand length |
| base1_o | output | 4 | First base register |
| disp1_o | output | 12 | First displacement |
| base2_o | output | 4 | Second base register |
| disp2_o | output | 12 | Second displacement |

## Verification
Every one of the 256 opcodes is streamed back to back, first with the consumer always ready and then with an irregular ready pattern. This catches a length decode that swallows or leaks a byte. Such a fault shifts every later record, so the opcode of the following instruction turns up in the wrong field. The first pass also catches a design that idles for a cycle at an instruction boundary, or that drops the record a cycle late. The stalled pass catches bytes that are accepted while a record is held, which would corrupt the record or lose an instruction. A fault in the opcode list or in the field masking shows up as wrong length nibbles, or as leftover nonzero bytes in unused fields. Flush is applied both mid-instruction and over a waiting record. A design that keeps stale bytes would then misparse the next opcode, and one that keeps the waiting record would emit a record that was never requested.

// File: rtl/insn_byte_aligner.sv
module insn_byte_aligner #(
  parameter int NDUAL = 4,
  parameter logic [8*NDUAL-1:0] DUAL_OPS = 32'hF2F3F8FA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_byte,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  op_o,
  output logic [2:0]  fmt_o,
  output logic [2:0]  len_o,
  output logic [3:0]  ra_o,
  output logic [3:0]  rb_o,
  output logic [7:0]  imm_o,
  output logic [7:0]  len8_o,
  output logic [3:0]  lhi_o,
  output logic [3:0]  llo_o,
  output logic [3:0]  base1_o,
  output logic [11:0] disp1_o,
  output logic [3:0]  base2_o,
  output logic [11:0] disp2_o
);

  localparam int MAXB = 6;
  localparam logic [2:0] F_RR  = 3'd0;
  localparam logic [2:0] F_RX  = 3'd1;
  localparam logic [2:0] F_RS  = 3'd2;
  localparam logic [2:0] F_SI  = 3'd3;
  localparam logic [2:0] F_SSL = 3'd4;
  localparam logic [2:0] F_SSD = 3'd5;

  logic [7:0] cur [MAXB];
  logic [7:0] ob  [MAXB];
  logic [2:0] cnt, need, ofmt, fmt_cur;
  logic       ov, dual, take_in, last;

  function automatic logic [2:0] len_of(input logic [7:0] op);
    case (op[7:6])
      2'b00:   return 3'd2;
      2'b11:   return 3'd6;
      default: return 3'd4;
    endcase
  endfunction

  always_comb begin
    dual = 1'b0;
    for (int i = 0; i < NDUAL; i++)
      if (cur[0] == DUAL_OPS[8*i +: 8]) dual = 1'b1;
  end

  always_comb begin
    case (cur[0][7:6])
      2'b00:   fmt_cur = F_RR;
      2'b01:   fmt_cur = F_RX;
      2'b10:   fmt_cur = cur[0][5] ? F_SI : F_RS;
      default: fmt_cur = dual ? F_SSD : F_SSL;
    endcase
  end

  assign in_ready = !flush && (!ov || out_ready);
  assign take_in  = in_valid && in_ready;
  assign last     = take_in && (cnt != 3'd0) && (cnt + 3'd1 == need);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      need <= '0;
      ov   <= 1'b0;
      ofmt <= F_RR;
      for (int k = 0; k < MAXB; k++) begin
        cur[k] <= '0;
        ob[k]  <= '0;
      end
    end else if (flush) begin
      cnt <= '0;
      ov  <= 1'b0;
    end else begin
      if (ov && out_ready) ov <= 1'b0;
      if (take_in) begin
        for (int k = 0; k < MAXB; k++)
          if (cnt == 3'(k)) cur[k] <= in_byte;
        if (cnt == 3'd0) begin
          need <= len_of(in_byte);
          cnt  <= 3'd1;
        end else if (last) begin
          cnt  <= '0;
          ov   <= 1'b1;
          ofmt <= fmt_cur;
          for (int k = 0; k < MAXB; k++)
            ob[k] <= (3'(k) < cnt) ? cur[k] : ((3'(k) == cnt) ? in_byte : 8'h00);
        end else begin
          cnt <= cnt + 3'd1;
        end
      end
    end
  end

  wire reg_fmt = (ofmt == F_RR) || (ofmt == F_RX) || (ofmt == F_RS);
  wire ss_fmt  = (ofmt == F_SSL) || (ofmt == F_SSD);

  assign out_valid = ov;
  assign op_o    = ob[0];
  assign fmt_o   = ofmt;
  assign len_o   = (ofmt == F_RR) ? 3'd2 : (ss_fmt ? 3'd6 : 3'd4);
  assign ra_o    = reg_fmt ? ob[1][7:4] : 4'h0;
  assign rb_o    = reg_fmt ? ob[1][3:0] : 4'h0;
  assign imm_o   = (ofmt == F_SI)  ? ob[1] : 8'h00;
  assign len8_o  = (ofmt == F_SSL) ? ob[1] : 8'h00;
  assign lhi_o   = (ofmt == F_SSD) ? ob[1][7:4] : 4'h0;
  assign llo_o   = (ofmt == F_SSD) ? ob[1][3:0] : 4'h0;
  assign base1_o = (ofmt != F_RR) ? ob[2][7:4] : 4'h0;
  assign disp1_o = (ofmt != F_RR) ? {ob[2][3:0], ob[3]} : 12'h000;
  assign base2_o = ss_fmt ? ob[4][7:4] : 4'h0;
  assign disp2_o = ss_fmt ? {ob[4][3:0], ob[5]} : 12'h000;

  // R1
  len_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((len_o == 3'd2) == (op_o[7:6] == 2'b00)) &&
                  ((len_o == 3'd6) == (op_o[7:6] == 2'b11)));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 3'd0) || (cnt < need));

  // R8
  hold_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=>
      (out_valid && $stable(op_o) && $stable(disp1_o) && $stable(disp2_o) && $stable(ra_o)));

  // R8
  stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  prompt_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> out_valid);

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && cnt == 3'd0));

endmodule

// File: tb/insn_byte_aligner_bench.sv
module insn_byte_aligner_bench;
  logic clk = 1'b0;
  logic rst_n, flush, in_valid, out_ready;
  logic [7:0] in_byte;
  logic in_ready, out_valid;
  logic [7:0] op_o, imm_o, len8_o;
  logic [2:0] fmt_o, len_o;
  logic [3:0] ra_o, rb_o, lhi_o, llo_o, base1_o, base2_o;
  logic [11:0] disp1_o, disp2_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  insn_byte_aligner u_insn_byte_aligner (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready), .op_o(op_o),
    .fmt_o(fmt_o), .len_o(len_o), .ra_o(ra_o), .rb_o(rb_o), .imm_o(imm_o),
    .len8_o(len8_o), .lhi_o(lhi_o), .llo_o(llo_o), .base1_o(base1_o),
    .disp1_o(disp1_o), .base2_o(base2_o), .disp2_o(disp2_o));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int ilen(input int op);
    if (op[7:6] == 2'b00) return 2;
    if (op[7:6] == 2'b11) return 6;
    return 4;
  endfunction

  function automatic int efmt(input int op);
    if (op[7:6] == 2'b00) return 0;
    if (op[7:6] == 2'b01) return 1;
    if (op[7:6] == 2'b10) return op[5] ? 3 : 2;
    return (op == 'hF2 || op == 'hF3 || op == 'hF8 || op == 'hFA) ? 5 : 4;
  endfunction

  function automatic int gen(input int op, input int k, input int p);
    return (op * (k + 3) + k * 29 + p * 71) & 255;
  endfunction

  task automatic cmp_rec(input int op, input int p);
    int f, b2, b3, b4, b5, b6;
    f  = efmt(op);
    b2 = gen(op, 1, p);
    b3 = (ilen(op) > 2) ? gen(op, 2, p) : 0;
    b4 = (ilen(op) > 2) ? gen(op, 3, p) : 0;
    b5 = (ilen(op) > 4) ? gen(op, 4, p) : 0;
    b6 = (ilen(op) > 4) ? gen(op, 5, p) : 0;
    chk(int'(op_o) == op, "R1", "opcode", op_o, op);
    chk(int'(len_o) == ilen(op), "R1", "length", len_o, ilen(op));
    chk(int'(fmt_o) == f, "R2", "format", fmt_o, f);
    // R3 and R7: register nibbles
    chk(int'(ra_o) == ((f <= 2) ? (b2 >> 4) : 0), "R3", "ra", ra_o, (f <= 2) ? (b2 >> 4) : 0);
    chk(int'(rb_o) == ((f <= 2) ? (b2 & 15) : 0), "R3", "rb", rb_o, (f <= 2) ? (b2 & 15) : 0);
    // R4 and R7
    chk(int'(imm_o) == ((f == 3) ? b2 : 0), "R4", "imm", imm_o, (f == 3) ? b2 : 0);
    // R5 and R7
    chk(int'(len8_o) == ((f == 4) ? b2 : 0), "R5", "len8", len8_o, (f == 4) ? b2 : 0);
    chk(int'(lhi_o) == ((f == 5) ? (b2 >> 4) : 0), "R5", "lhi", lhi_o, (f == 5) ? (b2 >> 4) : 0);
    chk(int'(llo_o) == ((f == 5) ? (b2 & 15) : 0), "R5", "llo", llo_o, (f == 5) ? (b2 & 15) : 0);
    // R6 and R7
    chk(int'(base1_o) == (b3 >> 4), "R6", "base1", base1_o, b3 >> 4);
    chk(int'(disp1_o) == (((b3 & 15) << 8) | b4), "R6", "disp1", disp1_o, ((b3 & 15) << 8) | b4);
    chk(int'(base2_o) == (b5 >> 4), "R6", "base2", base2_o, b5 >> 4);
    chk(int'(disp2_o) == (((b5 & 15) << 8) | b6), "R7", "disp2", disp2_o, ((b5 & 15) << 8) | b6);
  endtask

  task automatic sweep(input int p);
    int drv_i = 0, drv_k = 0, mon_i = 0;
    bit prev_stall = 0, expect_next = 0;
    while (mon_i < 256) begin
      @(negedge clk);
      out_ready = (p == 0) ? 1'b1 : (((cyc * 7) % 5) < 3);
      if (drv_i < 256) begin
        in_valid = 1'b1;
        in_byte  = 8'((drv_k == 0) ? drv_i : gen(drv_i, drv_k, p));
      end else begin
        in_valid = 1'b0;
      end
      #2;
      if (prev_stall) chk(out_valid, "R8", "record dropped while stalled", out_valid, 1);
      if (expect_next) chk(out_valid, "R9", "record late", out_valid, 1);
      if (p == 0 && drv_i < 256) chk(in_ready, "R9", "bubble on input", in_ready, 1);
      if (out_valid && !out_ready) chk(!in_ready, "R8", "input taken while stalled", in_ready, 0);
      if (out_valid && out_ready) begin
        cmp_rec(mon_i, p);
        mon_i++;
      end
      prev_stall  = out_valid && !out_ready;
      expect_next = 0;
      if (in_valid && in_ready) begin
        drv_k++;
        if (drv_k == ilen(drv_i)) begin
          drv_k = 0;
          drv_i++;
          expect_next = 1;
        end
      end
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    flush    = 1'b0;
    in_valid = 1'b1;
    in_byte  = b;
  endtask

  initial begin
    rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_byte = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(!out_valid, "R11", "out_valid after reset", out_valid, 0);
    chk(in_ready, "R11", "in_ready after reset", in_ready, 1);

    sweep(0);
    sweep(1);

    // R10: flush mid-instruction, then a register-register instruction
    out_ready = 1'b1;
    put(8'h45);
    put(8'h12);
    @(negedge clk);
    in_valid = 1'b0; flush = 1'b1;
    #2;
    chk(!in_ready, "R10", "in_ready during flush", in_ready, 0);
    @(negedge clk);
    flush = 1'b0;
    #2;
    chk(!out_valid, "R10", "no record after flush", out_valid, 0);
    put(8'h1A);
    put(8'h68);
    @(negedge clk);
    in_valid = 1'b0;
    #2;
    chk(out_valid, "R10", "record after flush", out_valid, 1);
    chk(op_o == 8'h1A, "R10", "opcode after flush", op_o, 'h1A);
    chk(fmt_o == 3'd0 && ra_o == 4'h6 && rb_o == 4'h8, "R10", "fields after flush",
        {fmt_o, ra_o, rb_o}, 'h068);

    // R10: flush over a pending record
    @(negedge clk);
    out_ready = 1'b0;
    put(8'h07);
    put(8'hF8);
    @(negedge clk);
    in_valid = 1'b0;
    #2;
    chk(out_valid && !in_ready, "R8", "pending record stalls input", {out_valid, in_ready}, 2);
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    #2;
    chk(!out_valid, "R10", "pending record dropped", out_valid, 0);
    chk(in_ready, "R10", "ready after flush", in_ready, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule